// File: doc/BRIEF.md
# Interrupt Entry State Sequencer

This block performs the register updates a processor core makes at the moment it takes a peripheral module interrupt. The core presents its live program counter, status word, general register 15 and vector base, together with a one-cycle accept strobe, the interrupt event code and the priority level of the interrupt being taken. On a clock edge where the strobe is honoured, the block does all of the following at once:

- It copies the live program counter, status word and R15 into three save registers.
- It records the event code.
- It forms the handler's status word by setting the privileged-mode, bank-select and exception-block bits.
- When the mask-update control input is high, it also replaces the interrupt mask with the accepted level.
- It forms the handler address as the vector base plus a fixed offset.

A small state machine records what happened to the last strobe. There are four states:

- `ST_IDLE`: no strobe was seen at the last edge.
- `ST_ENTERED`: the entry was committed.
- `ST_IGNORED`: the strobe was refused because exceptions were already blocked.
- `ST_BADCODE`: the strobe was refused because the event code was malformed.

Every state moves on each edge:

- With no strobe, it goes to `ST_IDLE`.
- A strobe while the live status word's block bit is set goes to `ST_IGNORED`.
- Otherwise, a strobe with an illegal code goes to `ST_BADCODE`.
- Otherwise, a strobe goes to `ST_ENTERED`.

Each of the three outcome flags is high exactly while its state is held. The core copies `new_sr` and `new_pc` into its architectural registers after seeing `taken`.

Top module: `irq_entry_seq`

## Requirements
- R1: On a committed entry, `saved_pc`, `saved_sr` and `saved_r15` take the values `cur_pc`, `cur_sr` and `cur_r15` had at the accepting clock edge.
- R2: On a committed entry, `evt_reg` takes the value of `evt_code` at the accepting edge.
- R3: An event code is legal only when it is a multiple of 0x20 and lies between 0x0000_0400 and 0x0000_3FE0, inclusive. A strobe carrying an illegal code (and a clear block bit) commits nothing and raises `code_err` for one cycle.
- R4: On a committed entry, `new_sr` equals `cur_sr` with bit 30 (privileged mode), bit 29 (bank select) and bit 28 (exception block) forced to 1. Every other bit is copied, except for the mask field covered by R5.
- R5: The interrupt mask is `new_sr[7:4]`. It takes `irq_level` when `mask_upd` is 1 at the accepting edge, and otherwise keeps `cur_sr[7:4]`.
- R6: On a committed entry, `new_pc` equals `vbr + 0x600`, modulo 2^32.
- R7: A strobe arriving while `cur_sr[28]` is 1 changes no output register and raises `ignored` for one cycle. This refusal takes precedence over a code error on the same strobe.
- R8: On an edge without a strobe, every output register holds its value and all three flags are low after that edge.
- R9: After reset, all output registers and flags are zero. At most one of `taken`, `ignored` and `code_err` is high in any cycle, and `taken` is high for exactly the one cycle after a committed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| accept | input | 1 | Interrupt accept strobe, one cycle |
| evt_code | input | 32 | Event code of the accepted source |
| irq_level | input | 4 | Priority level of the accepted interrupt |
| mask_upd | input | 1 | When 1, entry loads the mask field with `irq_level` |
| cur_pc | input | 32 | Live program counter |
| cur_sr | input | 32 | Live status word |
| cur_r15 | input | 32 | Live general register 15 |
| vbr | input | 32 | Vector base |
| saved_pc | output | 32 | Saved program counter |
| saved_sr | output | 32 | Saved status word |
| saved_r15 | output | 32 | Saved R15 |
| evt_reg | output | 32 | Recorded event code |
| new_sr | output | 32 | Status word for the handler |
| new_pc | output | 32 | Handler address |
| taken | output | 1 | Entry committed at the last edge |
| ignored | output | 1 | Strobe refused at the last edge because exceptions were blocked |
| code_err | output | 1 | Strobe refused at the last edge because the event code was illegal |

## Verification
Two functions can fall in the same cycle:

- The blocked-exception refusal and the code legality check can both apply to a single strobe.
- The mask update and the forcing of the three mode bits both act on the same status word.

The bench provokes the first pair by sending strobes with the block bit set and an out-of-range or misaligned code. It judges them by expecting only `ignored`, with every register unchanged from its previous value. For the second pair, it sweeps all sixteen levels with `mask_upd` both high and low over status words whose mode bits and mask are already partly set. It compares the whole of `new_sr` against a word it computes arithmetically.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    // Outcome of the most recent clock edge
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ENTERED = 2'd1,
        ST_IGNORED = 2'd2,
        ST_BADCODE = 2'd3
    } entry_state_e;

    // Status word bit positions decoded by the core
    localparam int SR_MD_BIT = 30;
    localparam int SR_RB_BIT = 29;
    localparam int SR_BL_BIT = 28;

    // Save slots inside the context register file
    localparam int SLOT_PC    = 0;
    localparam int SLOT_SR    = 1;
    localparam int SLOT_R15   = 2;
    localparam int SLOT_EVT   = 3;
    localparam int SLOT_NSR   = 4;
    localparam int SLOT_NPC   = 5;
    localparam int SLOT_COUNT = 6;

endpackage

// File: rtl/irq_code_check.sv
module irq_code_check #(
    parameter int XLEN       = 32,
    parameter int ALIGN_BITS = 5,
    parameter int CODE_MIN   = 'h400,
    parameter int CODE_MAX   = 'h3FE0
) (
    input  logic [XLEN-1:0] code,
    output logic            legal
);
    localparam logic [XLEN-1:0] MIN_W = XLEN'(CODE_MIN);
    localparam logic [XLEN-1:0] MAX_W = XLEN'(CODE_MAX);

    logic aligned;
    logic in_range;

    always_comb begin
        aligned  = (code[ALIGN_BITS-1:0] == '0);
        in_range = (code >= MIN_W) && (code <= MAX_W);
        legal    = aligned && in_range;
    end

endmodule

// File: rtl/irq_sr_compose.sv
module irq_sr_compose
    import irq_entry_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int MASK_W   = 4,
    parameter int MASK_LSB = 4
) (
    input  logic [XLEN-1:0]   cur_sr,
    input  logic [MASK_W-1:0] level,
    input  logic              mask_upd,
    output logic [XLEN-1:0]   sr_next
);
    always_comb begin
        sr_next            = cur_sr;
        sr_next[SR_MD_BIT] = 1'b1;
        sr_next[SR_RB_BIT] = 1'b1;
        sr_next[SR_BL_BIT] = 1'b1;
        if (mask_upd) begin
            sr_next[MASK_LSB +: MASK_W] = level;
        end
    end

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accept,
    input  logic         blocked,
    input  logic         code_legal,
    output logic         commit,
    output entry_state_e state,
    output logic         taken,
    output logic         ignored,
    output logic         code_err
);
    entry_state_e state_nx;

    // Next-state decision, made in any present state
    always_comb begin
        state_nx = ST_IDLE;
        commit   = 1'b0;
        unique case (state)
            ST_IDLE, ST_ENTERED, ST_IGNORED, ST_BADCODE: begin
                if (!accept) begin
                    state_nx = ST_IDLE;
                end else if (blocked) begin
                    state_nx = ST_IGNORED;
                end else if (!code_legal) begin
                    state_nx = ST_BADCODE;
                end else begin
                    state_nx = ST_ENTERED;
                    commit   = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Output decode
    always_comb begin
        taken    = 1'b0;
        ignored  = 1'b0;
        code_err = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_ENTERED: taken    = 1'b1;
            ST_IGNORED: ignored  = 1'b1;
            ST_BADCODE: code_err = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/irq_ctx_regs.sv
module irq_ctx_regs #(
    parameter int XLEN  = 32,
    parameter int SLOTS = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [SLOTS-1:0][XLEN-1:0] d,
    output logic [SLOTS-1:0][XLEN-1:0] q
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[s] <= '0;
            end else if (load) begin
                q[s] <= d[s];
            end
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int MASK_W     = 4,
    parameter int MASK_LSB   = 4,
    parameter int VEC_OFFSET = 'h600,
    parameter int ALIGN_BITS = 5,
    parameter int CODE_MIN   = 'h400,
    parameter int CODE_MAX   = 'h3FE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [XLEN-1:0]   evt_code,
    input  logic [MASK_W-1:0] irq_level,
    input  logic              mask_upd,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   cur_sr,
    input  logic [XLEN-1:0]   cur_r15,
    input  logic [XLEN-1:0]   vbr,
    output logic [XLEN-1:0]   saved_pc,
    output logic [XLEN-1:0]   saved_sr,
    output logic [XLEN-1:0]   saved_r15,
    output logic [XLEN-1:0]   evt_reg,
    output logic [XLEN-1:0]   new_sr,
    output logic [XLEN-1:0]   new_pc,
    output logic              taken,
    output logic              ignored,
    output logic              code_err
);
    localparam logic [XLEN-1:0] VEC_OFF_W = XLEN'(VEC_OFFSET);

    logic                            code_legal;
    logic                            commit;
    logic [XLEN-1:0]                 sr_next;
    logic [SLOT_COUNT-1:0][XLEN-1:0] slot_d;
    logic [SLOT_COUNT-1:0][XLEN-1:0] slot_q;
    entry_state_e                    state;

    irq_code_check #(
        .XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS),
        .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)
    ) u_code (
        .code  (evt_code),
        .legal (code_legal)
    );

    irq_sr_compose #(
        .XLEN(XLEN), .MASK_W(MASK_W), .MASK_LSB(MASK_LSB)
    ) u_sr (
        .cur_sr   (cur_sr),
        .level    (irq_level),
        .mask_upd (mask_upd),
        .sr_next  (sr_next)
    );

    irq_entry_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .blocked    (cur_sr[SR_BL_BIT]),
        .code_legal (code_legal),
        .commit     (commit),
        .state      (state),
        .taken      (taken),
        .ignored    (ignored),
        .code_err   (code_err)
    );

    always_comb begin
        slot_d           = '0;
        slot_d[SLOT_PC]  = cur_pc;
        slot_d[SLOT_SR]  = cur_sr;
        slot_d[SLOT_R15] = cur_r15;
        slot_d[SLOT_EVT] = evt_code;
        slot_d[SLOT_NSR] = sr_next;
        slot_d[SLOT_NPC] = vbr + VEC_OFF_W;
    end

    irq_ctx_regs #(.XLEN(XLEN), .SLOTS(SLOT_COUNT)) u_ctx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (commit),
        .d     (slot_d),
        .q     (slot_q)
    );

    always_comb begin
        saved_pc  = slot_q[SLOT_PC];
        saved_sr  = slot_q[SLOT_SR];
        saved_r15 = slot_q[SLOT_R15];
        evt_reg   = slot_q[SLOT_EVT];
        new_sr    = slot_q[SLOT_NSR];
        new_pc    = slot_q[SLOT_NPC];
    end

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
    import irq_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int MASK_W     = 4,
    parameter int MASK_LSB   = 4,
    parameter int VEC_OFFSET = 'h600,
    parameter int ALIGN_BITS = 5,
    parameter int CODE_MIN   = 'h400,
    parameter int CODE_MAX   = 'h3FE0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              accept,
    input logic [XLEN-1:0]   evt_code,
    input logic [MASK_W-1:0] irq_level,
    input logic              mask_upd,
    input logic [XLEN-1:0]   cur_pc,
    input logic [XLEN-1:0]   cur_sr,
    input logic [XLEN-1:0]   cur_r15,
    input logic [XLEN-1:0]   vbr,
    input logic [XLEN-1:0]   saved_pc,
    input logic [XLEN-1:0]   saved_sr,
    input logic [XLEN-1:0]   saved_r15,
    input logic [XLEN-1:0]   evt_reg,
    input logic [XLEN-1:0]   new_sr,
    input logic [XLEN-1:0]   new_pc,
    input logic              taken,
    input logic              ignored,
    input logic              code_err
);
    logic code_ok;

    always_comb begin
        code_ok = (evt_code % XLEN'(1 << ALIGN_BITS) == '0)
               && (evt_code >= XLEN'(CODE_MIN))
               && (evt_code <= XLEN'(CODE_MAX));
    end

    // R1
    a_r1_context_saved: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !cur_sr[SR_BL_BIT] && code_ok |=>
            saved_pc == $past(cur_pc) && saved_sr == $past(cur_sr)
            && saved_r15 == $past(cur_r15) && taken);

    // R2
    a_r2_code_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> evt_reg == $past(evt_code));

    // R3
    a_r3_bad_code_refused: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !cur_sr[SR_BL_BIT] && !code_ok |=>
            code_err && $stable(evt_reg) && $stable(new_pc));

    // R4
    a_r4_mode_bits_set: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> new_sr[SR_MD_BIT] && new_sr[SR_RB_BIT] && new_sr[SR_BL_BIT]);

    // R5
    a_r5_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
        taken && !$past(mask_upd) |->
            new_sr[MASK_LSB +: MASK_W] == saved_sr[MASK_LSB +: MASK_W]);

    // R6
    a_r6_vector_target: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> new_pc == $past(vbr) + XLEN'(VEC_OFFSET));

    // R7
    a_r7_blocked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cur_sr[SR_BL_BIT] |=>
            ignored && $stable(saved_pc) && $stable(new_sr));

    // R8
    a_r8_hold_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(saved_sr) && $stable(evt_reg) && $stable(new_pc)
            && !taken && !ignored && !code_err);

    // R9
    a_r9_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({taken, ignored, code_err}));

endmodule

bind irq_entry_seq irq_entry_chk #(
    .XLEN(XLEN), .MASK_W(MASK_W), .MASK_LSB(MASK_LSB), .VEC_OFFSET(VEC_OFFSET),
    .ALIGN_BITS(ALIGN_BITS), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)
) u_chk (.*);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        accept = 1'b0;
    logic [31:0] evt_code = '0;
    logic [3:0]  irq_level = '0;
    logic        mask_upd = 1'b0;
    logic [31:0] cur_pc = '0, cur_sr = '0, cur_r15 = '0, vbr = '0;
    logic [31:0] saved_pc, saved_sr, saved_r15, evt_reg, new_sr, new_pc;
    logic        taken, ignored, code_err;

    int total = 0;
    int bad = 0;

    // Expected model
    logic [31:0] e_pc = '0, e_sr = '0, e_r15 = '0, e_evt = '0, e_nsr = '0, e_npc = '0;

    always #5 clk = ~clk;

    irq_entry_seq u0 (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic et, input logic ei, input logic ee);
        chk("R1", {req, " saved_pc"},  saved_pc,  e_pc);
        chk("R1", {req, " saved_sr"},  saved_sr,  e_sr);
        chk("R1", {req, " saved_r15"}, saved_r15, e_r15);
        chk("R2", {req, " evt_reg"},   evt_reg,   e_evt);
        chk("R4", {req, " new_sr"},    new_sr,    e_nsr);
        chk("R6", {req, " new_pc"},    new_pc,    e_npc);
        chk("R9", {req, " taken"},     {31'd0, taken},    {31'd0, et});
        chk("R7", {req, " ignored"},   {31'd0, ignored},  {31'd0, ei});
        chk("R3", {req, " code_err"},  {31'd0, code_err}, {31'd0, ee});
    endtask

    // Drive one strobe at a falling edge, check after the next rising edge
    task automatic strobe(input string req, input logic [31:0] pc, input logic [31:0] sr,
                          input logic [31:0] r15, input logic [31:0] vb,
                          input logic [31:0] code, input logic [3:0] lvl, input logic mu);
        logic legal;
        logic blk;
        logic [31:0] nsr;
        cur_pc = pc; cur_sr = sr; cur_r15 = r15; vbr = vb;
        evt_code = code; irq_level = lvl; mask_upd = mu; accept = 1'b1;
        legal = (code % 32 == 0) && (code >= 32'd1024) && (code <= 32'd16352);
        blk = sr[28];
        @(posedge clk);
        @(negedge clk);
        accept = 1'b0;
        if (!blk && legal) begin
            nsr = sr | 32'h7000_0000;
            if (mu) nsr = (nsr & ~32'h0000_00F0) | ({28'd0, lvl} * 32'd16);
            e_pc = pc; e_sr = sr; e_r15 = r15; e_evt = code;
            e_nsr = nsr; e_npc = vb + 32'd1536;
        end
        check_all(req, !blk && legal, blk, !blk && !legal);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check_all("R9 reset", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 after release", 1'b0, 1'b0, 1'b0);

        // R3 R2: code sweep across both range edges, every value
        for (int c = 'h3A0; c <= 'h440; c++) begin
            strobe("R3 low edge", 32'h1000_0000 + c, 32'h0000_0003, 32'hA5A5_0000 ^ c,
                   32'h8000_0000, c, 4'(c), c[0]);
        end
        for (int c = 'h3F80; c <= 'h4020; c++) begin
            strobe("R3 high edge", 32'h2000_0000 + c, 32'h0000_0050, ~c,
                   32'hFFFF_FC00, c, 4'(c >> 5), c[5]);
        end

        // R5 R4: all levels with and without mask update, over varied status words
        for (int l = 0; l < 16; l++) begin
            for (int m = 0; m < 2; m++) begin
                strobe("R5 level sweep", 32'h4000 + l, {1'b0, 3'(l & 6), 20'd0, 4'(15 - l), 4'h5},
                       32'(l * 7), 32'(l * 32'h1000), 32'h400 + 32'(l * 32), 4'(l), m[0]);
            end
        end

        // R6: vector base wrap-around
        strobe("R6 wrap", 32'h1, 32'h0, 32'h2, 32'hFFFF_FF00, 32'h600, 4'h9, 1'b1);

        // R7: blocked strobe with legal and illegal codes, precedence over code error
        strobe("R7 blocked legal", 32'hDEAD_0000, 32'h1000_0000, 32'h1, 32'h0, 32'h800, 4'h3, 1'b1);
        strobe("R7 blocked bad",   32'hDEAD_0001, 32'h7000_00F0, 32'h1, 32'h0, 32'h404, 4'h3, 1'b1);
        strobe("R7 blocked range", 32'hDEAD_0002, 32'h1000_0000, 32'h1, 32'h0, 32'h4000, 4'h3, 1'b0);

        // Back-to-back commits
        strobe("R1 back to back a", 32'h1111_1111, 32'h0, 32'h3333_3333, 32'h100, 32'h3FE0, 4'hF, 1'b1);
        strobe("R1 back to back b", 32'h2222_2222, 32'h0FFF_FFFF, 32'h4444_4444, 32'h200, 32'h400, 4'h0, 1'b1);

        // R8: quiet cycles with changing inputs
        for (int k = 0; k < 6; k++) begin
            cur_pc = 32'(k * 99); cur_sr = 32'(k); vbr = 32'(k * 5);
            evt_code = 32'h800; mask_upd = 1'b1;
            @(posedge clk);
            @(negedge clk);
            check_all("R8 quiet", 1'b0, 1'b0, 1'b0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule